// File: doc/BRIEF.md
# Over-Current Trip and Auto-Reclose Sequencer

This block watches the current readings of the four switching devices of one bridge and protects them when the current is too high. Each clock cycle in which the valid strobe is high, it compares every 9-bit current count against a programmable trip level. Any count above the level trips the block. It raises a common block signal that tells the gate driver to turn all four switches off. It also latches a flag for each device that exceeded the level.

After a trip, the block does not stay latched. It holds the bridge off for a protection dwell and then spends one cycle on a decision. If the retry budget is not used up, it releases the bridge for a reclose window, clears the flags and watches the current again. A clean window returns it to normal running and refills the budget. A trip inside the window counts as a failed attempt and goes straight back to the protection dwell. After four failed attempts, the decision cycle enters a long lockout instead. At the end of the lockout the block returns to normal with a full budget. All three dwell lengths are cycle-count parameters, so a system clock of any rate can be used and simulation can shorten them.

Top module: `oc_reclose_guard`

## Requirements
- R1: While reset is active, and right after it is released, `bridge_block` is 0 and `oc_flag` is all zeros.
- R2: Device i occupies bits [9i+8:9i] of `cur_cnt`. A device trips only when its count is strictly greater than `trip_level`; a count equal to the level never trips. On a trip, bit i of `oc_flag` is set for each device that exceeded the level.
- R3: Counts presented while `cnt_valid` is 0 are ignored: neither `bridge_block` nor `oc_flag` responds.
- R4: An over-level sample taken at a clock edge during normal running produces no output change after that edge. After the following edge, `bridge_block` is 1 and the flags are set.
- R5: After a trip, `bridge_block` stays 1 for PROT_CYC cycles of protection plus one decision cycle. When the bridge is then released for a reclose, `oc_flag` is cleared in the same cycle.
- R6: If a reclose window of RECL_CYC cycles passes without a trip, the block returns to normal and the failed-attempt count is cleared. A later persistent fault again gets the full number of attempts.
- R7: A trip during the reclose window goes straight back to protection, with no decision cycle in between. It sets the flags for the offending devices and counts one failed attempt.
- R8: Once MAX_TRIES attempts have failed, the decision cycle enters a lockout. The bridge stays blocked for LOCK_CYC cycles and the flags are held for the whole lockout. The block then returns to normal with the flags and the attempt count cleared.
- R9: Over-level samples that arrive during protection, during the decision cycle or during the lockout change neither the flags nor the dwell timing.
- R10: When several devices exceed the level in the same sample, all of their flags are set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_valid | input | 1 | Qualifies `cur_cnt` for this cycle |
| cur_cnt | input | NDEV*CNT_W (36) | Packed current counts, device 0 in the lowest bits |
| trip_level | input | CNT_W (9) | Programmable protection point |
| bridge_block | output | 1 | Forces all bridge switches off when 1 |
| oc_flag | output | NDEV (4) | Sticky per-device over-current flags |

## Verification
The situation hardest to reach from the ports is a lockout that follows exactly the permitted number of failed recloses. Each failed reclose leaves the bridge released for only a single cycle. The stimulus holds two devices above the level without a break, so each reclose window fails at once. It counts the released cycles across the whole episode, expecting exactly four, and removes the fault part-way into the lockout so that the return to normal can be seen. The same episode is run a second time after a trip sequence that fails once and then recovers. Seeing four released cycles again shows that the recovery refilled the retry budget.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_TRIPPED = 3'd1,
        ST_JUDGE   = 3'd2,
        ST_RETRY   = 3'd3,
        ST_LOCKOUT = 3'd4
    } oc_state_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/oc_hit_detect.sv
module oc_hit_detect #(
    parameter int unsigned NDEV  = 4,
    parameter int unsigned CNT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_valid,
    input  logic [NDEV*CNT_W-1:0]   cur_cnt,
    input  logic [CNT_W-1:0]        trip_level,
    output logic [NDEV-1:0]         hit_q
);

    logic [NDEV-1:0] above;
    logic [NDEV-1:0] hit_d;

    for (genvar g = 0; g < NDEV; g++) begin : g_cmp
        assign above[g] = cur_cnt[g*CNT_W +: CNT_W] > trip_level;
    end

    always_comb begin
        hit_d = cnt_valid ? above : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= '0;
        end else begin
            hit_q <= hit_d;
        end
    end

endmodule

// File: rtl/oc_dwell_timer.sv
module oc_dwell_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/oc_seq_ctrl.sv
module oc_seq_ctrl
    import oc_pkg::*;
#(
    parameter int unsigned NDEV      = 4,
    parameter int unsigned MAX_TRIES = 4,
    parameter int unsigned TW        = 8,
    parameter int unsigned PROT_CYC  = 80000,
    parameter int unsigned RECL_CYC  = 80000,
    parameter int unsigned LOCK_CYC  = 40000000,
    localparam int unsigned TRW      = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NDEV-1:0]  hit,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             block,
    output logic [NDEV-1:0]  flags,
    output oc_state_e        state,
    output logic [TRW-1:0]   tries
);

    localparam logic [TW-1:0]  PROT_V = TW'(PROT_CYC - 1);
    localparam logic [TW-1:0]  RECL_V = TW'(RECL_CYC - 1);
    localparam logic [TW-1:0]  LOCK_V = TW'(LOCK_CYC - 1);
    localparam logic [TRW-1:0] MAX_V  = TRW'(MAX_TRIES);

    typedef struct packed {
        oc_state_e        state;
        logic [NDEV-1:0]  flags;
        logic [TRW-1:0]   tries;
        logic             block;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_RUN, flags: '0, tries: '0, block: 1'b0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (seq_q.state)
            ST_RUN: begin
                if (|hit) begin
                    seq_d.state = ST_TRIPPED;
                    seq_d.flags = hit;
                    tmr_load    = 1'b1;
                    tmr_val     = PROT_V;
                end
            end
            ST_TRIPPED: begin
                if (tmr_expired) begin
                    seq_d.state = ST_JUDGE;
                end
            end
            ST_JUDGE: begin
                tmr_load = 1'b1;
                if (seq_q.tries < MAX_V) begin
                    seq_d.state = ST_RETRY;
                    seq_d.flags = '0;
                    tmr_val     = RECL_V;
                end else begin
                    seq_d.state = ST_LOCKOUT;
                    tmr_val     = LOCK_V;
                end
            end
            ST_RETRY: begin
                if (|hit) begin
                    seq_d.state = ST_TRIPPED;
                    seq_d.flags = hit;
                    seq_d.tries = seq_q.tries + 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = PROT_V;
                end else if (tmr_expired) begin
                    seq_d.state = ST_RUN;
                    seq_d.tries = '0;
                end
            end
            ST_LOCKOUT: begin
                if (tmr_expired) begin
                    seq_d.state = ST_RUN;
                    seq_d.tries = '0;
                    seq_d.flags = '0;
                end
            end
            default: begin
                seq_d = SEQ_RST;
            end
        endcase
        seq_d.block = (seq_d.state == ST_TRIPPED) ||
                      (seq_d.state == ST_JUDGE)   ||
                      (seq_d.state == ST_LOCKOUT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign block = seq_q.block;
    assign flags = seq_q.flags;
    assign state = seq_q.state;
    assign tries = seq_q.tries;

endmodule

// File: rtl/oc_reclose_guard.sv
module oc_reclose_guard
    import oc_pkg::*;
#(
    parameter int unsigned NDEV      = 4,
    parameter int unsigned CNT_W     = 9,
    parameter int unsigned MAX_TRIES = 4,
    parameter int unsigned PROT_CYC  = 80000,
    parameter int unsigned RECL_CYC  = 80000,
    parameter int unsigned LOCK_CYC  = 40000000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cnt_valid,
    input  logic [NDEV*CNT_W-1:0]  cur_cnt,
    input  logic [CNT_W-1:0]       trip_level,
    output logic                   bridge_block,
    output logic [NDEV-1:0]        oc_flag
);

    localparam int unsigned LONGEST = max3(PROT_CYC, RECL_CYC, LOCK_CYC);
    localparam int unsigned TW      = $clog2(LONGEST + 1);
    localparam int unsigned TRW     = $clog2(MAX_TRIES + 1);

    logic [NDEV-1:0] hit_vec;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_expired;
    oc_state_e       seq_state;
    logic [TRW-1:0]  seq_tries;

    oc_hit_detect #(
        .NDEV  (NDEV),
        .CNT_W (CNT_W)
    ) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_valid  (cnt_valid),
        .cur_cnt    (cur_cnt),
        .trip_level (trip_level),
        .hit_q      (hit_vec)
    );

    oc_dwell_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    oc_seq_ctrl #(
        .NDEV      (NDEV),
        .MAX_TRIES (MAX_TRIES),
        .TW        (TW),
        .PROT_CYC  (PROT_CYC),
        .RECL_CYC  (RECL_CYC),
        .LOCK_CYC  (LOCK_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit_vec),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .block       (bridge_block),
        .flags       (oc_flag),
        .state       (seq_state),
        .tries       (seq_tries)
    );

endmodule

// File: rtl/oc_reclose_guard_chk.sv
module oc_reclose_guard_chk
    import oc_pkg::*;
#(
    parameter int unsigned NDEV      = 4,
    parameter int unsigned MAX_TRIES = 4,
    localparam int unsigned TRW      = $clog2(MAX_TRIES + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NDEV-1:0] hit,
    input oc_state_e       state_q,
    input logic [TRW-1:0]  tries,
    input logic            bridge_block,
    input logic [NDEV-1:0] oc_flag
);

    localparam logic [TRW-1:0] MAX_V = TRW'(MAX_TRIES);

    // R2
    trip_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && hit != '0) |=> (bridge_block && oc_flag == $past(hit)));

    // R5
    release_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && tries < MAX_V) |=> (state_q == ST_RETRY && oc_flag == '0 && !bridge_block));

    // R7
    retrip_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETRY && hit != '0) |=> (state_q == ST_TRIPPED && tries == $past(tries) + 1'b1));

    // R8
    lockout_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && tries >= MAX_V) |=> (state_q == ST_LOCKOUT && bridge_block));

    // R8
    tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= MAX_V);

    // R6
    run_has_full_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (tries == '0));

    // R9
    judge_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE) |-> $stable(oc_flag));

endmodule

bind oc_reclose_guard oc_reclose_guard_chk #(
    .NDEV      (NDEV),
    .MAX_TRIES (MAX_TRIES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit          (hit_vec),
    .state_q      (seq_state),
    .tries        (seq_tries),
    .bridge_block (bridge_block),
    .oc_flag      (oc_flag)
);

// File: tb/test_oc_reclose_guard.sv
module test_oc_reclose_guard;

    localparam int NDEV = 4;
    localparam int CW   = 9;
    localparam int MAXT = 4;
    localparam int PROT = 20;
    localparam int RECL = 15;
    localparam int LOCK = 60;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cnt_valid = 1'b0;
    logic [NDEV*CW-1:0]   cur_cnt = '0;
    logic [CW-1:0]        trip_level = '0;
    logic                 bridge_block;
    logic [NDEV-1:0]      oc_flag;

    oc_reclose_guard #(
        .NDEV      (NDEV),
        .CNT_W     (CW),
        .MAX_TRIES (MAXT),
        .PROT_CYC  (PROT),
        .RECL_CYC  (RECL),
        .LOCK_CYC  (LOCK)
    ) i_oc_reclose_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_valid    (cnt_valid),
        .cur_cnt      (cur_cnt),
        .trip_level   (trip_level),
        .bridge_block (bridge_block),
        .oc_flag      (oc_flag)
    );

    always #4 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string req   = "R1";
    bit    done  = 1'b0;

    // Behavioural reference: phase 0 run, 1 protect, 2 decide, 3 reclose, 4 lockout
    int              m_phase = 0;
    int              m_left  = 0;
    int              m_fails = 0;
    logic [NDEV-1:0] m_flags = '0;
    logic [NDEV-1:0] m_seen  = '0;
    bit              m_live  = 1'b0;

    function automatic logic [NDEV-1:0] sample_now();
        logic [NDEV-1:0] r;
        r = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (cnt_valid && (int'(cur_cnt[i*CW +: CW]) > int'(trip_level))) r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic bit m_blocked();
        return (m_phase == 1) || (m_phase == 2) || (m_phase == 4);
    endfunction

    always @(posedge clk) begin
        logic [NDEV-1:0] fresh;
        fresh = sample_now();
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_fails = 0; m_flags = '0; fresh = '0;
        end else begin
            case (m_phase)
                0: if (m_seen != '0) begin
                       m_phase = 1; m_left = PROT; m_flags = m_seen;
                   end
                1: begin
                       m_left--;
                       if (m_left == 0) m_phase = 2;
                   end
                2: if (m_fails < MAXT) begin
                       m_phase = 3; m_left = RECL; m_flags = '0;
                   end else begin
                       m_phase = 4; m_left = LOCK;
                   end
                3: if (m_seen != '0) begin
                       m_phase = 1; m_left = PROT; m_flags = m_seen; m_fails++;
                   end else begin
                       m_left--;
                       if (m_left == 0) begin m_phase = 0; m_fails = 0; end
                   end
                default: begin
                       m_left--;
                       if (m_left == 0) begin m_phase = 0; m_fails = 0; m_flags = '0; end
                   end
            endcase
        end
        m_seen = fresh;
        m_live = 1'b1;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_live && !done) begin
            chk(req, "block vs model", 32'(bridge_block), 32'(m_blocked()));
            chk(req, "flags vs model", 32'(oc_flag), 32'(m_flags));
        end
    end

    task automatic set_dev(input int d, input int v);
        cur_cnt[d*CW +: CW] = CW'(v);
    endtask

    task automatic all_nominal();
        for (int i = 0; i < NDEV; i++) set_dev(i, 100);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic persistent_episode(input string tag);
        int lows;
        lows = 0;
        set_dev(0, 300);
        set_dev(3, 300);
        wait_n(1);
        for (int k = 1; k <= 130; k++) begin
            @(negedge clk);
            if (!bridge_block) lows++;
            if (k == 1) chk("R10", "both flags set", 32'(oc_flag), 32'b1001);
            if (k == 120) chk("R8", "lockout holds flags", 32'(oc_flag), 32'b1001);
        end
        all_nominal();
        chk(tag, "released cycles before lockout", 32'(lows), 32'(MAXT));
        wait_n(39);
        chk("R8", "still locked at last lockout cycle", 32'(bridge_block), 32'd1);
        chk("R9", "fault removal in lockout leaves flags", 32'(oc_flag), 32'b1001);
        wait_n(1);
        chk("R8", "lockout over, block", 32'(bridge_block), 32'd0);
        chk("R8", "lockout over, flags", 32'(oc_flag), 32'd0);
    endtask

    initial begin
        trip_level = 9'd200;
        all_nominal();
        rst_n = 1'b0;
        wait_n(3);
        chk("R1", "block in reset", 32'(bridge_block), 32'd0);
        chk("R1", "flags in reset", 32'(oc_flag), 32'd0);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", "block after reset", 32'(bridge_block), 32'd0);

        req = "R2";
        cnt_valid = 1'b1;
        wait_n(10);
        chk("R2", "below level no trip", 32'(bridge_block), 32'd0);
        set_dev(2, 200);
        wait_n(6);
        chk("R2", "equal to level no trip", 32'(bridge_block), 32'd0);
        set_dev(2, 100);

        req = "R3";
        cnt_valid = 1'b0;
        set_dev(0, 300);
        wait_n(6);
        chk("R3", "invalid counts ignored", 32'(bridge_block), 32'd0);
        chk("R3", "invalid counts no flag", 32'(oc_flag), 32'd0);
        set_dev(0, 100);
        cnt_valid = 1'b1;
        wait_n(2);

        req = "R4";
        set_dev(1, 201);
        wait_n(1);
        set_dev(1, 100);
        chk("R4", "no output after first edge", 32'(bridge_block), 32'd0);
        wait_n(1);
        chk("R4", "block after second edge", 32'(bridge_block), 32'd1);
        chk("R2", "flag of device 1", 32'(oc_flag), 32'b0010);

        req = "R9";
        wait_n(4);
        set_dev(3, 300);
        wait_n(1);
        set_dev(3, 100);
        wait_n(4);
        chk("R9", "hit during protect ignored", 32'(oc_flag), 32'b0010);

        req = "R5";
        wait_n(11);
        chk("R5", "decision cycle still blocked", 32'(bridge_block), 32'd1);
        wait_n(1);
        chk("R5", "released for reclose", 32'(bridge_block), 32'd0);
        chk("R5", "flags cleared on release", 32'(oc_flag), 32'd0);

        req = "R6";
        wait_n(25);
        chk("R6", "clean reclose back to run", 32'(bridge_block), 32'd0);

        req = "R7";
        persistent_episode("R7");
        wait_n(5);

        req = "R6";
        set_dev(2, 250);
        wait_n(1);
        set_dev(2, 100);
        wait_n(24);
        chk("R6", "in reclose window", 32'(bridge_block), 32'd0);
        set_dev(2, 250);
        wait_n(1);
        set_dev(2, 100);
        wait_n(1);
        chk("R7", "retrip in reclose blocks at once", 32'(bridge_block), 32'd1);
        chk("R7", "retrip flag of device 2", 32'(oc_flag), 32'b0100);
        wait_n(45);
        chk("R6", "recovered to run", 32'(bridge_block), 32'd0);
        persistent_episode("R6");

        wait_n(5);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule